// File: doc/BRIEF.md
# Frame Buffer Rectangle Transfer Sequencer

This block moves a rectangle of 16-bit pixels between a 32-bit host data port and a 1024 x 512 pixel frame buffer. The buffer sits behind a simple synchronous RAM port with one cycle of read latency. A start strobe brings in a position word and a size word, together with a direction bit. After that the host either pushes data words with a valid/ready handshake, or pops data words with a valid/acknowledge handshake. Every data word carries two pixels.

The sequencer walks the rectangle row by row and computes each pixel's linear address as y*1024+x. Both coordinates wrap: the column wraps at the right edge and the row wraps at the bottom edge. The column position is kept between data words, so an odd width or a stall on the host side simply resumes at the pixel where the walk stopped.

Writes can force bit 15 of every pixel they store. They can also protect destination pixels whose bit 15 is already set, using a read-then-write step. When a transfer ends, a one-cycle completion pulse is raised. A write whose rectangle overlaps the displayed area also raises a dirty pulse at that moment.

Top module: `vram_rect_xfer`

## Requirements
- R1: On start, x0 = pos_word[9:0] and y0 = pos_word[24:16]. The other bits of pos_word are ignored. The first pixel handled has address y0*1024+x0.
- R2: Width is size_word[9:0], with 0 meaning 1024. Height is size_word[24:16], with 0 meaning 512. The other bits of size_word are ignored.
- R3: Pixels go in row-major order. Pixel p lies at column (x0 + p mod W) mod 1024. Within a data word, bits 15:0 are the earlier pixel and bits 31:16 the later one.
- R4: The row of pixel p is (y0 + p div W) mod 512.
- R5: A row may end in the middle of a data word. Gaps between data words may fall anywhere. The walk continues at the next pixel and never restarts a row.
- R6: With force_mask high, every pixel written has bit 15 set. Otherwise bit 15 is passed through from the host data.
- R7: With check_mask high, each destination pixel is read first. It is written only if its stored bit 15 is 0.
- R8: In the read direction, each rd_data word packs two pixels in the same order as R3. When the pixel count is odd, the last word has bits 31:16 equal to 0. img_ready is high from the cycle after start until the last word is acknowledged.
- R9: done pulses for exactly one cycle per transfer. For a write this is the cycle the last pixel is handled; for a read it is the cycle the last word is acknowledged. busy is low in the following cycle.
- R10: dirty pulses together with done only for a write whose rectangle, taken without wrap, overlaps the display rectangle (disp_x, disp_y, disp_w, disp_h). A read never raises dirty.
- R11: A start strobe while busy is ignored. wr_ready is high only during a write transfer while a data word is awaited.
- R12: After reset, busy, img_ready, wr_ready, rd_valid, mem_we, mem_re, done and dirty are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (used only while idle) |
| start_read | input | 1 | Direction for start: 1 = frame buffer to host |
| pos_word | input | 32 | Start position word |
| size_word | input | 32 | Rectangle size word |
| force_mask | input | 1 | Set bit 15 on every written pixel |
| check_mask | input | 1 | Protect destination pixels with bit 15 set |
| disp_x | input | 10 | Display area left column |
| disp_y | input | 9 | Display area top row |
| disp_w | input | 11 | Display area width |
| disp_h | input | 10 | Display area height |
| wr_valid | input | 1 | Host write word valid |
| wr_data | input | 32 | Host write word (two pixels) |
| wr_ready | output | 1 | Write word accepted this cycle when valid |
| rd_data | output | 32 | Read word (two pixels) |
| rd_valid | output | 1 | Read word available |
| rd_ack | input | 1 | Host takes the read word |
| mem_addr | output | 19 | Frame buffer pixel address |
| mem_re | output | 1 | Frame buffer read strobe |
| mem_we | output | 1 | Frame buffer write strobe |
| mem_wdata | output | 16 | Frame buffer write pixel |
| mem_rdata | input | 16 | Frame buffer read pixel, one cycle after mem_re |
| busy | output | 1 | Transfer in progress |
| img_ready | output | 1 | Read transfer in progress |
| done | output | 1 | Transfer completion pulse |
| dirty | output | 1 | Display overlap pulse at write completion |

## Verification
The write path is exercised with several rectangle shapes. An even width fed one word per cycle shows the basic order. An odd width with idle gaps shows that rows resume mid-word instead of restarting. A rectangle at the bottom-right corner proves both coordinate wraps, and zero-coded sizes prove the 1024 and 512 decodes. Writes with force and with check over a preloaded pattern separate pass-through, forced and protected pixels. Read transfers of even and odd pixel counts separate correct packing from a stale upper half. A start pulse during a busy write, plus writes inside and outside the display area, separate ignored commands and correct dirty reporting.

// File: rtl/vrx_pkg.sv
package vrx_pkg;

    localparam int XW = 10;          // column bits: 1024 pixels per row
    localparam int YW = 9;           // row bits: 512 rows
    localparam int PW = 16;          // pixel width
    localparam int WW = 2 * PW;      // host word width
    localparam int AW = XW + YW;     // pixel address width
    localparam int YLSB = 16;        // row field starts at this bit of position/size words

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WGET,
        ST_WPIX,
        ST_WMRG,
        ST_RREQ,
        ST_RCAP,
        ST_RHOLD
    } xfer_st_t;

    typedef struct packed {
        logic [XW-1:0] x0;
        logic [YW-1:0] y0;
        logic [XW:0]   w;
        logic [YW:0]   h;
    } rect_t;

    // zero-coded extents stand for the full buffer span
    function automatic rect_t decode_rect(input logic [WW-1:0] pos, input logic [WW-1:0] size);
        rect_t r;
        r.x0 = pos[XW-1:0];
        r.y0 = pos[YLSB +: YW];
        r.w  = (size[XW-1:0] == '0) ? {1'b1, {XW{1'b0}}} : {1'b0, size[XW-1:0]};
        r.h  = (size[YLSB +: YW] == '0) ? {1'b1, {YW{1'b0}}} : {1'b0, size[YLSB +: YW]};
        return r;
    endfunction

    // plain interval overlap, no wrap
    function automatic logic rect_hits(input rect_t r,
                                       input logic [XW-1:0] dx, input logic [YW-1:0] dy,
                                       input logic [XW:0] dw, input logic [YW:0] dh);
        logic [XW+1:0] ax0, ax1, bx0, bx1;
        logic [YW+1:0] ay0, ay1, by0, by1;
        ax0 = {2'b00, r.x0};
        ax1 = ax0 + {1'b0, r.w};
        bx0 = {2'b00, dx};
        bx1 = bx0 + {1'b0, dw};
        ay0 = {2'b00, r.y0};
        ay1 = ay0 + {1'b0, r.h};
        by0 = {2'b00, dy};
        by1 = by0 + {1'b0, dh};
        return (ax0 < bx1) && (bx0 < ax1) && (ay0 < by1) && (by0 < ay1);
    endfunction

endpackage

// File: rtl/vrx_walker.sv
module vrx_walker
    import vrx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  rect_t         rect_in,
    input  logic          step,
    output rect_t         rect_q,
    output logic [AW-1:0] addr,
    output logic          last
);
    localparam logic [XW:0] COL_ONE = (XW+1)'(1);
    localparam logic [YW:0] ROW_ONE = (YW+1)'(1);

    logic [XW:0]   col;
    logic [YW-1:0] row_y;
    logic [YW:0]   rows_left;
    logic [XW-1:0] col_x;
    logic          row_end;

    assign col_x   = rect_q.x0 + col[XW-1:0];
    assign addr    = {row_y, col_x};
    assign row_end = (col == rect_q.w - COL_ONE);
    assign last    = row_end && (rows_left == ROW_ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            rect_q    <= '0;
            col       <= '0;
            row_y     <= '0;
            rows_left <= '0;
        end else if (load) begin
            rect_q    <= rect_in;
            col       <= '0;
            row_y     <= rect_in.y0;
            rows_left <= rect_in.h;
        end else if (step) begin
            if (row_end) begin
                col       <= '0;
                row_y     <= row_y + 1'b1;
                rows_left <= rows_left - ROW_ONE;
            end else begin
                col <= col + COL_ONE;
            end
        end
    end
endmodule

// File: rtl/vrx_pixmerge.sv
module vrx_pixmerge #(
    parameter int PIXW = 16
) (
    input  logic [PIXW-1:0] new_pix,
    input  logic [PIXW-1:0] old_pix,
    input  logic            force_m,
    input  logic            check_m,
    output logic [PIXW-1:0] pix_out,
    output logic            allow
);
    assign pix_out = {new_pix[PIXW-1] | force_m, new_pix[PIXW-2:0]};
    assign allow   = !(check_m && old_pix[PIXW-1]);
endmodule

// File: rtl/vram_rect_xfer.sv
module vram_rect_xfer
    import vrx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_read,
    input  logic [31:0]   pos_word,
    input  logic [31:0]   size_word,
    input  logic          force_mask,
    input  logic          check_mask,
    input  logic [9:0]    disp_x,
    input  logic [8:0]    disp_y,
    input  logic [10:0]   disp_w,
    input  logic [9:0]    disp_h,
    input  logic          wr_valid,
    input  logic [31:0]   wr_data,
    output logic          wr_ready,
    output logic [31:0]   rd_data,
    output logic          rd_valid,
    input  logic          rd_ack,
    output logic [18:0]   mem_addr,
    output logic          mem_re,
    output logic          mem_we,
    output logic [15:0]   mem_wdata,
    input  logic [15:0]   mem_rdata,
    output logic          busy,
    output logic          img_ready,
    output logic          done,
    output logic          dirty
);
    xfer_st_t      state;
    logic          is_read;
    logic          half;
    logic          rd_final;
    logic [WW-1:0] word_q;
    logic [WW-1:0] rd_word;

    rect_t         rect_new;
    rect_t         rect_q;
    logic          load;
    logic          step;
    logic          last;
    logic [PW-1:0] cur_pix;
    logic [PW-1:0] merged;
    logic          allow;
    logic          wr_plain;
    logic          unused_bits;

    assign unused_bits = ^{pos_word[WW-1:YLSB+YW], pos_word[YLSB-1:XW],
                           size_word[WW-1:YLSB+YW], size_word[YLSB-1:XW]};

    assign rect_new = decode_rect(pos_word, size_word);
    assign load     = (state == ST_IDLE) && start;
    assign cur_pix  = half ? word_q[WW-1:PW] : word_q[PW-1:0];
    assign wr_plain = (state == ST_WPIX) && !check_mask;
    assign step     = wr_plain || (state == ST_WMRG) || (state == ST_RCAP);

    vrx_walker u_walk (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .rect_in (rect_new),
        .step    (step),
        .rect_q  (rect_q),
        .addr    (mem_addr),
        .last    (last)
    );

    vrx_pixmerge #(.PIXW(PW)) u_merge (
        .new_pix (cur_pix),
        .old_pix (mem_rdata),
        .force_m (force_mask),
        .check_m (check_mask),
        .pix_out (merged),
        .allow   (allow)
    );

    assign mem_wdata = merged;
    assign mem_we    = wr_plain || ((state == ST_WMRG) && allow);
    assign mem_re    = ((state == ST_WPIX) && check_mask) || (state == ST_RREQ);
    assign wr_ready  = (state == ST_WGET);
    assign rd_valid  = (state == ST_RHOLD);
    assign rd_data   = rd_word;
    assign busy      = (state != ST_IDLE);
    assign img_ready = busy && is_read;
    assign done      = ((wr_plain || (state == ST_WMRG)) && last)
                     || ((state == ST_RHOLD) && rd_ack && rd_final);
    assign dirty     = done && !is_read && rect_hits(rect_q, disp_x, disp_y, disp_w, disp_h);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            is_read  <= 1'b0;
            half     <= 1'b0;
            rd_final <= 1'b0;
            word_q   <= '0;
            rd_word  <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        is_read  <= start_read;
                        half     <= 1'b0;
                        rd_final <= 1'b0;
                        rd_word  <= '0;
                        state    <= start_read ? ST_RREQ : ST_WGET;
                    end
                end
                ST_WGET: begin
                    if (wr_valid) begin
                        word_q <= wr_data;
                        half   <= 1'b0;
                        state  <= ST_WPIX;
                    end
                end
                ST_WPIX, ST_WMRG: begin
                    if ((state == ST_WPIX) && check_mask) begin
                        state <= ST_WMRG;
                    end else if (last) begin
                        state <= ST_IDLE;
                    end else if (!half) begin
                        half  <= 1'b1;
                        state <= ST_WPIX;
                    end else begin
                        state <= ST_WGET;
                    end
                end
                ST_RREQ: begin
                    state <= ST_RCAP;
                end
                ST_RCAP: begin
                    if (half) rd_word[WW-1:PW] <= mem_rdata;
                    else      rd_word[PW-1:0]  <= mem_rdata;
                    if (last) begin
                        rd_final <= 1'b1;
                        state    <= ST_RHOLD;
                    end else if (!half) begin
                        half  <= 1'b1;
                        state <= ST_RREQ;
                    end else begin
                        state <= ST_RHOLD;
                    end
                end
                ST_RHOLD: begin
                    if (rd_ack) begin
                        if (rd_final) begin
                            state <= ST_IDLE;
                        end else begin
                            half    <= 1'b0;
                            rd_word <= '0;
                            state   <= ST_RREQ;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vram_rect_xfer_chk.sv
module vram_rect_xfer_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        img_ready,
    input logic        done,
    input logic        dirty,
    input logic        mem_we,
    input logic        mem_re,
    input logic [15:0] mem_wdata,
    input logic [15:0] mem_rdata,
    input logic        force_mask,
    input logic        check_mask,
    input logic        wr_ready,
    input logic        rd_valid
);
    a_r9_idle_after_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);
    a_r9_single_done: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r8_img_in_busy: assert property (@(posedge clk) disable iff (rst)
        img_ready |-> busy);
    a_r8_rd_valid_read: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> img_ready);
    a_r10_dirty_write_done: assert property (@(posedge clk) disable iff (rst)
        dirty |-> (done && !img_ready));
    a_r6_forced_top: assert property (@(posedge clk) disable iff (rst)
        (mem_we && force_mask) |-> mem_wdata[15]);
    a_r7_guarded_write: assert property (@(posedge clk) disable iff (rst)
        (mem_we && check_mask) |-> ($past(mem_re) && !mem_rdata[15]));
    a_r11_ready_on_write: assert property (@(posedge clk) disable iff (rst)
        wr_ready |-> (busy && !img_ready));
    a_r12_port_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && mem_re));
endmodule

bind vram_rect_xfer vram_rect_xfer_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .img_ready  (img_ready),
    .done       (done),
    .dirty      (dirty),
    .mem_we     (mem_we),
    .mem_re     (mem_re),
    .mem_wdata  (mem_wdata),
    .mem_rdata  (mem_rdata),
    .force_mask (force_mask),
    .check_mask (check_mask),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid)
);

// File: tb/vram_rect_xfer_bench.sv
`timescale 1ns/1ps
module vram_rect_xfer_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0, start_read = 1'b0;
    logic [31:0] pos_word = '0, size_word = '0;
    logic        force_mask = 1'b0, check_mask = 1'b0;
    logic [9:0]  disp_x = 10'd0;
    logic [8:0]  disp_y = 9'd0;
    logic [10:0] disp_w = 11'd320;
    logic [9:0]  disp_h = 10'd240;
    logic        wr_valid = 1'b0;
    logic [31:0] wr_data = '0;
    logic        wr_ready;
    logic [31:0] rd_data;
    logic        rd_valid;
    logic        rd_ack = 1'b0;
    logic [18:0] mem_addr;
    logic        mem_re, mem_we;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        busy, img_ready, done, dirty;

    always #4 clk = ~clk;

    vram_rect_xfer u_vram_rect_xfer (.*);

    int nchk = 0, nerr = 0;
    int cyc = 0;
    bit wd_expired = 1'b0;
    int done_cnt = 0, dirty_cnt = 0;
    string cur_tag = "R3";
    int exp_addr_q[$];
    int exp_data_q[$];
    logic [15:0] ram [int];

    function automatic logic [15:0] rd_ram(input int a);
        return ram.exists(a) ? ram[a] : 16'h0000;
    endfunction

    function automatic logic [15:0] pv(input int seed, input int p);
        return 16'((seed * 7919 + p * 37 + (p % 5) * 9001) & 32'hffff);
    endfunction

    function automatic int pix_addr(input int x0, input int y0, input int w, input int p);
        return (((y0 + p / w) % 512) * 1024) + ((x0 + p % w) % 1024);
    endfunction

    task automatic chk(input string tag, input longint act, input longint exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) wd_expired <= 1'b1;
        if (mem_we) ram[int'(mem_addr)] = mem_wdata;
        if (mem_re) mem_rdata <= rd_ram(int'(mem_addr));
    end

    // per-cycle comparison of every frame buffer write against the model
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) begin
                if (exp_addr_q.size() == 0) begin
                    chk({cur_tag, " unexpected write"}, int'(mem_addr), -1);
                end else begin
                    chk({cur_tag, " write address"}, int'(mem_addr), exp_addr_q.pop_front());
                    chk({cur_tag, " write pixel"}, int'(mem_wdata), exp_data_q.pop_front());
                end
            end
            if (done) done_cnt++;
            if (dirty) dirty_cnt++;
        end
    end

    function automatic bit hits(input int x0, input int y0, input int w, input int h);
        return (x0 < disp_x + disp_w) && (disp_x < x0 + w) &&
               (y0 < disp_y + disp_h) && (disp_y < y0 + h);
    endfunction

    task automatic run_write(input logic [31:0] pos, input logic [31:0] size, input int seed,
                             input bit fm, input bit cm, input int gap, input bit poke,
                             input string tag);
        int x0 = int'(pos[9:0]);
        int y0 = int'(pos[24:16]);
        int w  = (size[9:0] == 0) ? 1024 : int'(size[9:0]);
        int h  = (size[24:16] == 0) ? 512 : int'(size[24:16]);
        int np = w * h;
        int nw = (np + 1) / 2;
        int exp_dirty = hits(x0, y0, w, h) ? 1 : 0;
        cur_tag = tag;
        for (int p = 0; p < np; p++) begin
            int a = pix_addr(x0, y0, w, p);
            logic [15:0] v = pv(seed, p);
            if (!(cm && rd_ram(a)[15])) begin
                exp_addr_q.push_back(a);
                exp_data_q.push_back(int'({v[15] | fm, v[14:0]}));
            end
        end
        done_cnt = 0; dirty_cnt = 0;
        @(negedge clk);
        start = 1'b1; start_read = 1'b0; pos_word = pos; size_word = size;
        force_mask = fm; check_mask = cm;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < nw && !wd_expired; k++) begin
            wr_valid = 1'b1;
            wr_data = {pv(seed, 2 * k + 1), pv(seed, 2 * k)};
            if (poke && k == 1) begin
                start = 1'b1; start_read = 1'b1; pos_word = 32'h0100_0200;
            end
            while (!wr_ready && !wd_expired) @(negedge clk);
            @(negedge clk);
            wr_valid = 1'b0;
            start = 1'b0; start_read = 1'b0;
            repeat (gap) @(negedge clk);
        end
        while (busy && !wd_expired) @(negedge clk);
        @(negedge clk);
        chk({tag, " all writes seen"}, exp_addr_q.size(), 0);
        chk("R9 one done per write", done_cnt, 1);
        chk("R9 busy low after done", busy, 0);
        chk("R10 dirty on write", dirty_cnt, exp_dirty);
        exp_addr_q.delete(); exp_data_q.delete();
    endtask

    task automatic run_read(input logic [31:0] pos, input logic [31:0] size, input int seed,
                            input string tag);
        int x0 = int'(pos[9:0]);
        int y0 = int'(pos[24:16]);
        int w  = (size[9:0] == 0) ? 1024 : int'(size[9:0]);
        int h  = (size[24:16] == 0) ? 512 : int'(size[24:16]);
        int np = w * h;
        int nw = (np + 1) / 2;
        cur_tag = tag;
        for (int p = 0; p < np; p++) ram[pix_addr(x0, y0, w, p)] = pv(seed, p);
        done_cnt = 0; dirty_cnt = 0;
        @(negedge clk);
        start = 1'b1; start_read = 1'b1; pos_word = pos; size_word = size;
        @(negedge clk);
        start = 1'b0;
        chk("R8 img_ready after start", img_ready, 1);
        for (int k = 0; k < nw && !wd_expired; k++) begin
            logic [15:0] lo = pv(seed, 2 * k);
            logic [15:0] hi = (2 * k + 1 < np) ? pv(seed, 2 * k + 1) : 16'h0000;
            while (!rd_valid && !wd_expired) @(negedge clk);
            chk({tag, " read word"}, rd_data, {hi, lo});
            chk("R8 img_ready held", img_ready, 1);
            rd_ack = 1'b1;
            @(negedge clk);
            rd_ack = 1'b0;
        end
        chk("R8 img_ready cleared", img_ready, 0);
        chk("R9 one done per read", done_cnt, 1);
        chk("R10 no dirty on read", dirty_cnt, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R12 busy at reset", busy, 0);
        chk("R12 img_ready at reset", img_ready, 0);
        chk("R12 wr_ready at reset", wr_ready, 0);
        chk("R12 rd_valid at reset", rd_valid, 0);
        chk("R12 mem strobes at reset", {mem_we, mem_re, done, dirty}, 0);
        rst = 1'b0;
        @(negedge clk);
        // R1 R2: ignored high bits in both words, 4x2 at (5,3), overlaps display
        run_write(32'hFE03_FC05, 32'hFE02_FC04, 1, 0, 0, 0, 0, "R1");
        // R5: odd width with idle gaps between words
        run_write(32'h0010_0020, 32'h0003_0003, 2, 0, 0, 3, 0, "R5");
        // R3 R4: column and row wrap at the corner, outside display
        run_write(32'h01FF_03FE, 32'h0002_0004, 3, 0, 0, 1, 0, "R4");
        // R6: forced top bit
        run_write(32'h0040_0100, 32'h0002_0005, 4, 1, 0, 0, 0, "R6");
        // R7: preload protected pixels, then guarded write with force
        for (int p = 0; p < 12; p++)
            ram[pix_addr(700, 400, 6, p)] = (p % 3 == 0) ? 16'h8000 | 16'(p) : 16'(p);
        run_write(32'h0190_02BC, 32'h0002_0006, 5, 1, 1, 0, 0, "R7");
        // R11: start while busy is ignored
        run_write(32'h0020_0030, 32'h0002_0004, 6, 0, 0, 0, 1, "R11");
        // R2: zero width means 1024 (wraps from column 10), zero height means 512
        run_write(32'h0050_000A, 32'h0001_0000, 7, 0, 0, 0, 0, "R2");
        run_write(32'h01F0_0200, 32'h0000_0001, 8, 0, 0, 0, 0, "R2");
        // R8: even and odd pixel counts
        run_read(32'h0005_0300, 32'h0002_0003, 9, "R8");
        run_read(32'h01FF_03FF, 32'h0001_0003, 10, "R8");
        // R3 after read: a plain write still works
        run_write(32'h0000_0000, 32'h0001_0002, 11, 0, 0, 0, 0, "R3");
        if (wd_expired) begin
            nchk++; nerr++;
            $display("FAIL watchdog: actual=expired expected=finished");
        end
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule